// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block sits between a set of DMA channel pairs and the one system-bus master port they share. Each pair owns a receive requester and a transmit requester. A requester signals with a ready pulse that it wants one transfer. The arbiter remembers every pulse as a pending request. Each time the bus port is free, it hands exactly one pending request to the port.

The choice among pending requests follows three rules, applied in this order. Any pending receive request beats every pending transmit request. Inside the chosen class, the request that has waited longest goes first; each pending request carries a saturating age counter for this. When ages are equal, the lower pair number wins. A grant covers one transfer only and is held until the bus port reports that transfer as done. A requester that wants another transfer must pulse again.

A grant is presented as a one-hot vector and as an index, together with a valid flag. Receive requester of pair i has index i. Transmit requester of pair i has index NUM_PAIRS+i.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, grant_o is all zeros, grant_idx_o is 0 and grant_valid_o is low.
- R2: A request pulse of a single cycle, sampled at rising edge k while the arbiter holds no grant, is latched as pending; the grant for it becomes visible after edge k+1. A grant is only ever given to a request that was pending.
- R3: Further pulses from a source whose request is already pending add nothing: that source gets one grant, and once it is served no further grant follows.
- R4: A grant stays unchanged while bus_done_i is low. At the rising edge that samples bus_done_i high, the next winner is loaded directly, so back-to-back grants need no idle cycle.
- R5: Whenever any receive request is pending, the next grant goes to a receive requester, however long a transmit request has waited.
- R6: Within one class, a request that has waited longer is granted before a newer one, regardless of pair number.
- R7: Among requests of one class with equal age, the lowest pair number is granted first.
- R8: If no request is pending when a grant is issued or released, grant_o is all zeros, grant_idx_o is 0 and grant_valid_o is low.
- R9: grant_o is one-hot or zero. When grant_valid_o is high, bit grant_idx_o of grant_o is set. Receive pair i has index i and transmit pair i has index NUM_PAIRS+i.
- R10: Ages saturate at 2^AGE_W-1. Two requests of one class that have both reached saturation fall back to pair-number order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_req_i | input | NUM_PAIRS | Receive ready pulses, one per channel pair |
| tx_req_i | input | NUM_PAIRS | Transmit ready pulses, one per channel pair |
| bus_done_i | input | 1 | Bus port reports that the granted transfer has completed |
| grant_o | output | 2*NUM_PAIRS | One-hot grant: receive pairs in the low half, transmit pairs in the high half |
| grant_idx_o | output | $clog2(2*NUM_PAIRS) | Index of the granted requester |
| grant_valid_o | output | 1 | A grant is being held |

## Verification
The bound checker watches every cycle for the structural properties:
- the grant is one-hot or zero, and its index and valid flag agree with it;
- a grant is held steady while the bus is busy;
- only a request that was pending is ever granted;
- no transmit grant is issued while a receive request is pending;
- the valid flag drops when nothing is pending.

The ordering by age, the pair-number tie break, saturation, the folding of repeated pulses and the exact latencies depend on the history of the stimulus, so only the bench scenarios show them. The bench sweeps every subset of simultaneous requests and adds directed scenarios with staggered arrivals.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Request class: receive requests always outrank transmit requests
  typedef enum logic {
    CLS_RX = 1'b0,
    CLS_TX = 1'b1
  } req_cls_e;

endpackage

// File: rtl/arb_pend_track.sv
// Per-requester pending flag and saturating wait-age counter.
module arb_pend_track #(
  parameter int NREQ  = 8,
  parameter int AGE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREQ-1:0]       req_i,
  input  logic [NREQ-1:0]       clr_i,
  output logic [NREQ-1:0]       pend_o,
  output logic [NREQ*AGE_W-1:0] age_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    logic             pend_q, pend_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic             keep;

    // Next state: a request still pending keeps its age; a fresh one starts at zero
    always_comb begin
      keep  = pend_q & ~clr_i[g];
      pend_d = keep | req_i[g];
      if (keep) begin
        age_d = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;
      end else begin
        age_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        age_q  <= '0;
      end else begin
        pend_q <= pend_d;
        age_q  <= age_d;
      end
    end

    assign pend_o[g]                  = pend_q;
    assign age_o[g*AGE_W +: AGE_W]    = age_q;
  end

endmodule

// File: rtl/arb_oldest_pick.sv
// Picks the oldest pending request of one class; lowest position wins ties.
module arb_oldest_pick #(
  parameter int N     = 4,
  parameter int AGE_W = 4,
  localparam int SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       pend_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic               any_o,
  output logic [SW-1:0]      sel_o,
  output logic [N-1:0]       onehot_o
);

  logic [AGE_W-1:0] best;

  // Scan from the highest position down with >= so that the lowest wins on equal age
  always_comb begin
    any_o    = 1'b0;
    best     = '0;
    sel_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && (!any_o || (age_i[i*AGE_W +: AGE_W] >= best))) begin
        any_o = 1'b1;
        best  = age_i[i*AGE_W +: AGE_W];
        sel_o = SW'(i);
      end
    end
    if (any_o) begin
      onehot_o[sel_o] = 1'b1;
    end
  end

endmodule

// File: rtl/arb_grant_ctrl.sv
// Holds the current grant until the bus port reports completion.
module arb_grant_ctrl #(
  parameter int NREQ  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_done_i,
  input  logic             any_i,
  input  logic [NREQ-1:0]  win_oh_i,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic             fire_o,
  output logic [NREQ-1:0]  clr_o,
  output logic [NREQ-1:0]  grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);

  logic [NREQ-1:0]  grant_q, grant_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d;
  logic             load_en;

  // Arbitrate when idle or when the current transfer completes
  assign load_en = ~valid_q | bus_done_i;

  always_comb begin
    grant_d = '0;
    idx_d   = '0;
    valid_d = 1'b0;
    if (any_i) begin
      grant_d = win_oh_i;
      idx_d   = win_idx_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_en) begin
      grant_q <= grant_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign fire_o  = load_en;
  assign clr_o   = load_en ? grant_d : '0;
  assign grant_o = grant_q;
  assign idx_o   = idx_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int AGE_W     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PAIRS-1:0]                 rx_req_i,
  input  logic [NUM_PAIRS-1:0]                 tx_req_i,
  input  logic                                 bus_done_i,
  output logic [2*NUM_PAIRS-1:0]               grant_o,
  output logic [$clog2(2*NUM_PAIRS)-1:0]       grant_idx_o,
  output logic                                 grant_valid_o
);

  localparam int NREQ  = 2 * NUM_PAIRS;
  localparam int IDX_W = $clog2(NREQ);
  localparam int PW    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NREQ-1:0]       req_all, pend, clr;
  logic [NREQ*AGE_W-1:0] age;
  logic                  arb_fire;

  assign req_all = {tx_req_i, rx_req_i};

  arb_pend_track #(.NREQ(NREQ), .AGE_W(AGE_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (req_all),
    .clr_i  (clr),
    .pend_o (pend),
    .age_o  (age)
  );

  // One oldest-first picker per class
  logic                 pick_any [2];
  logic [PW-1:0]        pick_sel [2];
  logic [NUM_PAIRS-1:0] pick_oh  [2];

  for (genvar c = 0; c < 2; c++) begin : g_cls
    arb_oldest_pick #(.N(NUM_PAIRS), .AGE_W(AGE_W)) u_pick (
      .pend_i   (pend[c*NUM_PAIRS +: NUM_PAIRS]),
      .age_i    (age[c*NUM_PAIRS*AGE_W +: NUM_PAIRS*AGE_W]),
      .any_o    (pick_any[c]),
      .sel_o    (pick_sel[c]),
      .onehot_o (pick_oh[c])
    );
  end

  req_cls_e         win_cls;
  logic             win_any;
  logic [NREQ-1:0]  win_oh;
  logic [IDX_W-1:0] win_idx;

  // Class choice: receive first, transmit only when no receive is pending
  always_comb begin
    win_cls = pick_any[CLS_RX] ? CLS_RX : CLS_TX;
    win_any = pick_any[CLS_RX] | pick_any[CLS_TX];
    if (win_cls == CLS_RX) begin
      win_oh  = {{NUM_PAIRS{1'b0}}, pick_oh[CLS_RX]};
      win_idx = IDX_W'(pick_sel[CLS_RX]);
    end else begin
      win_oh  = {pick_oh[CLS_TX], {NUM_PAIRS{1'b0}}};
      win_idx = IDX_W'(NUM_PAIRS) + IDX_W'(pick_sel[CLS_TX]);
    end
  end

  arb_grant_ctrl #(.NREQ(NREQ), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_done_i (bus_done_i),
    .any_i      (win_any),
    .win_oh_i   (win_oh),
    .win_idx_i  (win_idx),
    .fire_o     (arb_fire),
    .clr_o      (clr),
    .grant_o    (grant_o),
    .idx_o      (grant_idx_o),
    .valid_o    (grant_valid_o)
  );

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NUM_PAIRS = 4,
  localparam int NREQ  = 2 * NUM_PAIRS,
  localparam int IDX_W = $clog2(NREQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_done,
  input logic [NREQ-1:0]  grant,
  input logic [IDX_W-1:0] grant_idx,
  input logic             grant_valid,
  input logic [NREQ-1:0]  pend,
  input logic             fire
);

  // R9
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[grant_idx]);

  // R8
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  // R4
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !bus_done) |=> ($stable(grant) && $stable(grant_idx)));

  // R2
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((grant & ~$past(pend)) == '0));

  // R5
  rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (pend[NUM_PAIRS-1:0] != '0)) |=> (grant_idx < IDX_W'(NUM_PAIRS)));

  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (pend == '0)) |=> !grant_valid);

endmodule

bind dma_req_arbiter arb_chk #(.NUM_PAIRS(NUM_PAIRS)) u_arb_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .bus_done    (bus_done_i),
  .grant       (grant_o),
  .grant_idx   (grant_idx_o),
  .grant_valid (grant_valid_o),
  .pend        (pend),
  .fire        (arb_fire)
);

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NP    = 4;
  localparam int NR    = 2 * NP;
  localparam int IW    = $clog2(NR);
  localparam int WD_CYCLES = 100000;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] rx_req, tx_req;
  logic          bus_done;
  logic [NR-1:0] grant;
  logic [IW-1:0] grant_idx;
  logic          grant_valid;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  dma_req_arbiter #(.NUM_PAIRS(NP), .AGE_W(4)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_req_i      (rx_req),
    .tx_req_i      (tx_req),
    .bus_done_i    (bus_done),
    .grant_o       (grant),
    .grant_idx_o   (grant_idx),
    .grant_valid_o (grant_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Compare all grant outputs with an expected requester (or none)
  task automatic check_grant(input string tag, input bit exp_v, input int exp_i);
    logic [NR-1:0] eg;
    logic [IW-1:0] ei;
    eg = exp_v ? (NR'(1) << exp_i) : '0;
    ei = exp_v ? IW'(exp_i) : '0;
    n_cmp++;
    if (grant !== eg || grant_idx !== ei || grant_valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
               tag, grant, grant_idx, grant_valid, eg, ei, exp_v);
    end
  endtask

  // One-cycle pulse on a requester (index as in R9), then wait for it to be latched
  task automatic pulse(input int idx);
    if (idx < NP) rx_req[idx] = 1'b1;
    else          tx_req[idx-NP] = 1'b1;
    @(negedge clk);
    rx_req = '0;
    tx_req = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    rx_req   = '0;
    tx_req   = '0;
    bus_done = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: reset state
    check_grant("R1 reset", 1'b0, 0);

    // Sweep every subset of simultaneous pulses: equal ages, so order is ascending index
    for (int mask = 0; mask < (1 << NR); mask++) begin
      rx_req = mask[NP-1:0];
      tx_req = mask[NR-1:NP];
      @(negedge clk);
      rx_req = '0;
      tx_req = '0;
      @(negedge clk);
      for (int b = 0; b < NR; b++) begin
        if (mask[b]) begin
          check_grant("R2 R5 R7 R9 sweep", 1'b1, b);
          bus_done = 1'b1;
          @(negedge clk);
        end
      end
      check_grant("R8 sweep drained", 1'b0, 0);
      bus_done = 1'b0;
      @(negedge clk);
    end

    // R3 and R4: repeated pulses while pending, grant held while bus busy
    pulse(NP + 0);
    @(negedge clk);
    check_grant("R2 single pulse tx0", 1'b1, NP + 0);
    pulse(2);
    wait_cyc(2);
    pulse(2);
    pulse(2);
    wait_cyc(3);
    check_grant("R4 held while busy", 1'b1, NP + 0);
    bus_done = 1'b1;
    @(negedge clk);
    check_grant("R4 back-to-back rx2", 1'b1, 2);
    @(negedge clk);
    check_grant("R3 no second grant", 1'b0, 0);
    bus_done = 1'b0;
    @(negedge clk);

    // R5: old transmit request loses to a newer receive request
    pulse(1);
    @(negedge clk);
    check_grant("R2 rx1 granted", 1'b1, 1);
    pulse(NP + 2);
    wait_cyc(10);
    pulse(3);
    wait_cyc(2);
    bus_done = 1'b1;
    @(negedge clk);
    check_grant("R5 rx before older tx", 1'b1, 3);
    @(negedge clk);
    check_grant("R5 tx2 after rx", 1'b1, NP + 2);
    @(negedge clk);
    check_grant("R8 empty", 1'b0, 0);
    bus_done = 1'b0;
    @(negedge clk);

    // R6: older rx3 beats newer rx1
    pulse(0);
    @(negedge clk);
    pulse(3);
    wait_cyc(5);
    pulse(1);
    wait_cyc(2);
    bus_done = 1'b1;
    @(negedge clk);
    check_grant("R6 older rx3 first", 1'b1, 3);
    @(negedge clk);
    check_grant("R6 newer rx1 second", 1'b1, 1);
    @(negedge clk);
    check_grant("R8 empty", 1'b0, 0);
    bus_done = 1'b0;
    @(negedge clk);

    // R10: both ages saturated, so pair order decides
    pulse(NP + 3);
    @(negedge clk);
    pulse(3);
    wait_cyc(20);
    pulse(1);
    wait_cyc(20);
    bus_done = 1'b1;
    @(negedge clk);
    check_grant("R10 saturated tie rx1", 1'b1, 1);
    @(negedge clk);
    check_grant("R10 saturated tie rx3", 1'b1, 3);
    @(negedge clk);
    check_grant("R8 empty", 1'b0, 0);
    bus_done = 1'b0;
    wait_cyc(2);

    finish_run();
  end

endmodule